// File: doc/BRIEF.md
# Legacy PC Physical Memory Router

This block sits between a CPU-side request channel and the memory-like targets of a legacy PC address map. Each accepted request carries a byte address, a byte count of one to four and, for writes, up to four bytes of little-endian data. The router masks address bit 20 when the A20 gate is closed. It then steers the access to main memory, a video memory port, a shadow RAM port, an interrupt-controller register port, or nowhere. The option-ROM window from 0xC0000 to 0xFFFFF is governed by two tables of per-segment attributes, one for reads and one for writes.

Simple accesses are handled as one transfer on the main memory port. Any other access is broken into single-byte steps with an incrementing address, and each byte is routed on its own. Bytes that fall outside the installed memory read as 0xFF, and writes to them are lost without an error.

Requests use a valid/ready pair. `req_ready` is high only while the router is idle, so a request is held off for the whole of an access. Responses use a valid/ready pair as well. The response stays on the port, unchanged, for as long as `rsp_ready` is held low. No new request is taken until the response has been consumed.

Top module: `pc_mem_router`

## Requirements
- R1: When `a20_en` is 0, address bit 20 of every byte address is forced to 0 before any decode. When `a20_en` is 1, the address is used as given.
- R2: A byte below `MEM_BYTES` and outside 0xA0000–0xFFFFF, including 0x80000–0x9FFFF, is read from or written to the main memory port.
- R3: A byte in 0xA0000–0xBFFFF is passed one byte per strobe to the video port, at offset address−0xA0000, for both reads and writes.
- R4: In 0xC0000–0xFFFFF the segment index is address bits [17:14], and the attribute of segment k is bits [2k+1:2k] of the table. For a write, attribute 1 stores the byte in shadow RAM at offset address−0xC0000, and attribute 0 drops the byte.
- R5: For a read in 0xC0000–0xFFFFF, read-table attribute 1 returns the shadow RAM byte, and attribute 0 returns the byte from the main memory port.
- R6: An access is rejected with `rsp_err`=1 and no target strobe when any of its bytes meets a window attribute of 2 or 3, or when the length is not in 1–4.
- R7: A byte at or above `MEM_BYTES` reads as 0xFF, and a write to it is dropped. `rsp_err` stays 0.
- R8: An access of length 1, 2 or 4 whose masked start address is outside 0x80000–0xFFFFF, and which ends at or below `MEM_BYTES`, is one main-port transfer with `ram_be` of 0001/0011/1111. Its response is valid 2 clock edges after acceptance. Any other routed access takes one byte per cycle, and its response is valid 1+length edges after acceptance.
- R9: Data is little-endian. Byte i of `req_wdata`/`rsp_rdata` (bits [8i+7:8i]) belongs to address start+i. Unused read lanes, and all of `rsp_rdata` for writes, are 0.
- R10: When the masked start address lies in the local window (`LOC_BASE`, 4 KB) or the I/O window (`IO_BASE`, 4 KB), the whole access goes to the interrupt-controller port in one strobe. `ic_io` is 1 for the I/O window, and the response arrives 2 edges after acceptance carrying `ic_rdata` for reads.
- R11: After reset the router is idle, with `req_ready`=1, `busy`=0 and `rsp_valid`=0. `busy` is high from acceptance until the response handshake. The response and its data stay stable while `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a20_en | input | 1 | A20 gate; 0 clears address bit 20 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the lowest byte |
| req_len | input | 3 | Byte count, 1 to 4 |
| req_wdata | input | 32 | Little-endian write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed when high with rsp_valid |
| rsp_rdata | output | 32 | Little-endian read data |
| rsp_err | output | 1 | Access rejected without side effect |
| busy | output | 1 | Access in progress |
| rd_attr | input | 32 | Read attribute table, 2 bits per 16 KB segment |
| wr_attr | input | 32 | Write attribute table, 2 bits per 16 KB segment |
| ram_stb | output | 1 | Main memory strobe |
| ram_we | output | 1 | Main memory write enable |
| ram_addr | output | 32 | Main memory byte address |
| ram_be | output | 4 | Main memory byte lanes |
| ram_wdata | output | 32 | Main memory write data |
| ram_rdata | input | 32 | Main memory read data, same cycle |
| vid_stb | output | 1 | Video port strobe |
| vid_we | output | 1 | Video port write enable |
| vid_off | output | 17 | Video port byte offset |
| vid_wdata | output | 8 | Video port write byte |
| vid_rdata | input | 8 | Video port read byte, same cycle |
| shd_stb | output | 1 | Shadow RAM strobe |
| shd_we | output | 1 | Shadow RAM write enable |
| shd_off | output | 18 | Shadow RAM byte offset |
| shd_wdata | output | 8 | Shadow RAM write byte |
| shd_rdata | input | 8 | Shadow RAM read byte, same cycle |
| ic_stb | output | 1 | Interrupt-controller port strobe |
| ic_io | output | 1 | 1 = I/O window, 0 = local window |
| ic_we | output | 1 | Interrupt-controller write enable |
| ic_off | output | 12 | Offset inside the window |
| ic_len | output | 3 | Access length |
| ic_wdata | output | 32 | Write data |
| ic_rdata | input | 32 | Read data, same cycle |

## Verification
On every cycle, the embedded properties check the following:
- at most one target is strobed at a time;
- a closed A20 gate never lets bit 20 reach the main port;
- multi-lane transfers never start inside the 0x80000–0xFFFFF window;
- shadow writes occur only in segments whose write attribute is 1;
- no main-port write goes past installed memory;
- a stalled response holds steady.

Other behaviour can only be shown by the bench's scenarios, because it depends on what the targets hold. This covers:
- the routing of reads between shadow and main memory;
- 0xFF filling;
- little-endian lane order;
- the write drops and rejected accesses that must leave every target untouched;
- the latency split between the single transfer and the byte-serial path.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  localparam int ADDR_W = 32;
  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;
  localparam int LEN_W  = $clog2(LANES) + 1;
  localparam int VID_OW = 17;
  localparam int SHD_OW = 18;
  localparam int SEG_LSB = 14;

  localparam logic [ADDR_W-1:0] VID_LO   = 32'h000A_0000;
  localparam logic [ADDR_W-1:0] VID_HI   = 32'h000B_FFFF;
  localparam logic [ADDR_W-1:0] OPT_LO   = 32'h000C_0000;
  localparam logic [ADDR_W-1:0] OPT_HI   = 32'h000F_FFFF;
  localparam logic [ADDR_W-1:0] LEG_MASK = 32'hFFF8_0000;
  localparam logic [ADDR_W-1:0] LEG_BASE = 32'h0008_0000;

  localparam logic [1:0] ATTR_ROM    = 2'd0;
  localparam logic [1:0] ATTR_SHADOW = 2'd1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_t;
  typedef enum logic [2:0] {RG_RAM, RG_VID, RG_SHD, RG_ROM, RG_NONE, RG_BAD} region_t;

  function automatic logic [ADDR_W-1:0] gate_a20(input logic [ADDR_W-1:0] a, input logic en);
    return en ? a : (a & ~(32'h1 << 20));
  endfunction
endpackage

// File: rtl/pmr_attr_sel.sv
module pmr_attr_sel #(
  parameter int NSEG = 16,
  localparam int IW = $clog2(NSEG)
) (
  input  logic [2*NSEG-1:0] table_i,
  input  logic [IW-1:0]     idx_i,
  output logic [1:0]        attr_o
);
  assign attr_o = table_i[{idx_i, 1'b0} +: 2];
endmodule

// File: rtl/pmr_region_decode.sv
module pmr_region_decode
  import pmr_pkg::*;
#(
  parameter logic [32:0] MEM_BYTES = 33'h40_0000,
  parameter int NSEG = 16,
  localparam int IW = $clog2(NSEG)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [2*NSEG-1:0] rd_tbl_i,
  input  logic [2*NSEG-1:0] wr_tbl_i,
  output region_t           region_o
);
  logic [1:0] rd_a, wr_a, sel_a;

  pmr_attr_sel #(.NSEG(NSEG)) u_rd (.table_i(rd_tbl_i), .idx_i(addr_i[SEG_LSB +: IW]), .attr_o(rd_a));
  pmr_attr_sel #(.NSEG(NSEG)) u_wr (.table_i(wr_tbl_i), .idx_i(addr_i[SEG_LSB +: IW]), .attr_o(wr_a));

  assign sel_a = write_i ? wr_a : rd_a;

  always_comb begin
    if (addr_i >= VID_LO && addr_i <= VID_HI) begin
      region_o = RG_VID;
    end else if (addr_i >= OPT_LO && addr_i <= OPT_HI) begin
      case (sel_a)
        ATTR_ROM:    region_o = RG_ROM;
        ATTR_SHADOW: region_o = RG_SHD;
        default:     region_o = RG_BAD;
      endcase
    end else if ({1'b0, addr_i} < MEM_BYTES) begin
      region_o = RG_RAM;
    end else begin
      region_o = RG_NONE;
    end
  end
endmodule

// File: rtl/pmr_ic_match.sv
module pmr_ic_match
  import pmr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] LOC_BASE = 32'hFEE0_0000,
  parameter logic [ADDR_W-1:0] IO_BASE  = 32'hFEC0_0000,
  parameter int WIN_BYTES = 4096
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              io_o
);
  localparam logic [ADDR_W-1:0] WMASK = ~(ADDR_W'(WIN_BYTES) - 1);
  logic loc_hit, io_hit;
  assign loc_hit = (addr_i & WMASK) == LOC_BASE;
  assign io_hit  = (addr_i & WMASK) == IO_BASE;
  assign hit_o   = loc_hit | io_hit;
  assign io_o    = io_hit & ~loc_hit;
endmodule

// File: rtl/pc_mem_router.sv
module pc_mem_router
  import pmr_pkg::*;
#(
  parameter logic [32:0] MEM_BYTES = 33'h40_0000,
  parameter logic [31:0] LOC_BASE  = 32'hFEE0_0000,
  parameter logic [31:0] IO_BASE   = 32'hFEC0_0000,
  parameter int IC_WIN = 4096,
  parameter int NSEG   = 16,
  localparam int IC_OW = $clog2(IC_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a20_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [31:0]       req_addr,
  input  logic [2:0]        req_len,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              busy,
  input  logic [2*NSEG-1:0] rd_attr,
  input  logic [2*NSEG-1:0] wr_attr,
  output logic              ram_stb,
  output logic              ram_we,
  output logic [31:0]       ram_addr,
  output logic [3:0]        ram_be,
  output logic [31:0]       ram_wdata,
  input  logic [31:0]       ram_rdata,
  output logic              vid_stb,
  output logic              vid_we,
  output logic [16:0]       vid_off,
  output logic [7:0]        vid_wdata,
  input  logic [7:0]        vid_rdata,
  output logic              shd_stb,
  output logic              shd_we,
  output logic [17:0]       shd_off,
  output logic [7:0]        shd_wdata,
  input  logic [7:0]        shd_rdata,
  output logic              ic_stb,
  output logic              ic_io,
  output logic              ic_we,
  output logic [IC_OW-1:0]  ic_off,
  output logic [2:0]        ic_len,
  output logic [31:0]       ic_wdata,
  input  logic [31:0]       ic_rdata
);
  localparam int IXW = $clog2(LANES);

  state_t              state_q;
  logic [ADDR_W-1:0]   base_q;
  logic [LEN_W-1:0]    len_q;
  logic                wr_q, a20_q, err_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q;
  logic [IXW-1:0]      idx_q;

  logic [ADDR_W-1:0]   lane_addr [LANES];
  region_t             lane_rg   [LANES];
  logic [ADDR_W-1:0]   start, cur_addr;
  region_t             cur_rg;
  logic [7:0]          cur_byte, rd_byte;
  logic                len_ok, any_bad, run_bad, fast, ic_hit, ic_sel, last_step;
  logic [3:0]          fast_be;

  // one decoder per byte lane so a rejected access is known before any strobe
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_addr[g] = gate_a20(base_q + ADDR_W'(g), a20_q);
    pmr_region_decode #(.MEM_BYTES(MEM_BYTES), .NSEG(NSEG)) u_dec (
      .addr_i(lane_addr[g]), .write_i(wr_q),
      .rd_tbl_i(rd_attr), .wr_tbl_i(wr_attr), .region_o(lane_rg[g]));
  end

  pmr_ic_match #(.LOC_BASE(LOC_BASE), .IO_BASE(IO_BASE), .WIN_BYTES(IC_WIN)) u_ic (
    .addr_i(start), .hit_o(ic_hit), .io_o(ic_sel));

  assign start     = lane_addr[0];
  assign cur_addr  = lane_addr[idx_q];
  assign cur_rg    = lane_rg[idx_q];
  assign cur_byte  = wdata_q[8*idx_q +: 8];
  assign len_ok    = (len_q != '0) && (len_q <= LEN_W'(LANES));
  assign last_step = ({1'b0, idx_q} == len_q - LEN_W'(1));

  always_comb begin
    any_bad = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (LEN_W'(i) < len_q && lane_rg[i] == RG_BAD) any_bad = 1'b1;
  end

  assign run_bad = !len_ok || any_bad;
  assign fast = (len_q == 3'd1 || len_q == 3'd2 || len_q == 3'd4)
             && ((start & LEG_MASK) != LEG_BASE)
             && (({1'b0, start} + {30'b0, len_q}) <= MEM_BYTES);

  always_comb begin
    case (len_q)
      3'd1:    fast_be = 4'b0001;
      3'd2:    fast_be = 4'b0011;
      default: fast_be = 4'b1111;
    endcase
  end

  // target port steering
  always_comb begin
    ram_stb = 1'b0; ram_we = 1'b0; ram_addr = '0; ram_be = '0; ram_wdata = '0;
    vid_stb = 1'b0; vid_we = 1'b0; vid_off = '0; vid_wdata = '0;
    shd_stb = 1'b0; shd_we = 1'b0; shd_off = '0; shd_wdata = '0;
    ic_stb = 1'b0; ic_io = 1'b0; ic_we = 1'b0; ic_off = '0; ic_len = '0; ic_wdata = '0;
    if (state_q == ST_RUN && !run_bad) begin
      if (ic_hit) begin
        ic_stb = 1'b1; ic_io = ic_sel; ic_we = wr_q; ic_off = start[IC_OW-1:0];
        ic_len = len_q; ic_wdata = wdata_q;
      end else if (fast) begin
        ram_stb = 1'b1; ram_we = wr_q; ram_addr = start; ram_be = fast_be; ram_wdata = wdata_q;
      end else begin
        case (cur_rg)
          RG_RAM: begin
            ram_stb = 1'b1; ram_we = wr_q; ram_addr = cur_addr; ram_be = 4'b0001;
            ram_wdata = {24'b0, cur_byte};
          end
          RG_ROM: if (!wr_q) begin
            ram_stb = 1'b1; ram_addr = cur_addr; ram_be = 4'b0001;
          end
          RG_VID: begin
            vid_stb = 1'b1; vid_we = wr_q; vid_off = cur_addr[VID_OW-1:0]; vid_wdata = cur_byte;
          end
          RG_SHD: begin
            shd_stb = 1'b1; shd_we = wr_q; shd_off = cur_addr[SHD_OW-1:0]; shd_wdata = cur_byte;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (cur_rg)
      RG_RAM, RG_ROM: rd_byte = ram_rdata[7:0];
      RG_VID:         rd_byte = vid_rdata;
      RG_SHD:         rd_byte = shd_rdata;
      default:        rd_byte = 8'hFF;
    endcase
  end

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; base_q <= '0; len_q <= '0; wr_q <= 1'b0; a20_q <= 1'b0;
      err_q <= 1'b0; wdata_q <= '0; rdata_q <= '0; idx_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          base_q <= req_addr; len_q <= req_len; wr_q <= req_write; a20_q <= a20_en;
          wdata_q <= req_wdata; rdata_q <= '0; err_q <= 1'b0; idx_q <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (run_bad) begin
            err_q <= 1'b1; state_q <= ST_DONE;
          end else if (ic_hit) begin
            if (!wr_q) rdata_q <= ic_rdata;
            state_q <= ST_DONE;
          end else if (fast) begin
            if (!wr_q)
              for (int i = 0; i < LANES; i++)
                if (fast_be[i]) rdata_q[8*i +: 8] <= ram_rdata[8*i +: 8];
            state_q <= ST_DONE;
          end else begin
            if (!wr_q) rdata_q[8*idx_q +: 8] <= rd_byte;
            if (last_step) state_q <= ST_DONE;
            else idx_q <= idx_q + IXW'(1);
          end
        end
        ST_DONE: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_stb, vid_stb, shd_stb, ic_stb})); // R2
  AST_A20_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !a20_q && ram_stb) |-> !ram_addr[20]); // R1
  AST_WIDE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_stb && ram_be != 4'b0001) |-> ((ram_addr & LEG_MASK) != LEG_BASE)); // R8
  AST_SHD_WR_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
    (shd_stb && shd_we) |-> (wr_attr[{shd_off[17:14], 1'b0} +: 2] == ATTR_SHADOW)); // R4
  AST_RAM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_stb && ram_we) |-> ({1'b0, ram_addr} < MEM_BYTES)); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R11
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready)); // R11
endmodule

// File: tb/pc_mem_router_test.sv
module pc_mem_router_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [32:0] MEM = 33'h40_0000;
  localparam int unsigned K_RAM = 32'h0000_0000;
  localparam int unsigned K_VID = 32'h1000_0000;
  localparam int unsigned K_SHD = 32'h2000_0000;

  logic clk = 1'b0, rst_n = 1'b0, a20_en = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [2:0] req_len = 3'd1;
  logic req_ready, rsp_valid, rsp_err, busy;
  logic [31:0] rsp_rdata;
  logic [31:0] rtbl = '0, wtbl = '0;
  logic ram_stb, ram_we, vid_stb, vid_we, shd_stb, shd_we, ic_stb, ic_io, ic_we;
  logic [31:0] ram_addr, ram_wdata, ram_rdata, ic_wdata, ic_rdata;
  logic [3:0] ram_be;
  logic [16:0] vid_off; logic [17:0] shd_off; logic [11:0] ic_off; logic [2:0] ic_len;
  logic [7:0] vid_wdata, vid_rdata, shd_wdata, shd_rdata;

  int checks = 0, fails = 0, wgen = 0, stb_cnt = 0;
  bit done = 0;
  logic [7:0] dev_mem [int unsigned];
  logic [7:0] ref_mem [int unsigned];
  logic l_io, l_we; logic [11:0] l_off; logic [2:0] l_len; logic [31:0] l_wd;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_mem_router #(.MEM_BYTES(MEM)) uut (
    .clk, .rst_n, .a20_en, .req_valid, .req_ready, .req_write, .req_addr, .req_len,
    .req_wdata, .rsp_valid, .rsp_ready, .rsp_rdata, .rsp_err, .busy,
    .rd_attr(rtbl), .wr_attr(wtbl),
    .ram_stb, .ram_we, .ram_addr, .ram_be, .ram_wdata, .ram_rdata,
    .vid_stb, .vid_we, .vid_off, .vid_wdata, .vid_rdata,
    .shd_stb, .shd_we, .shd_off, .shd_wdata, .shd_rdata,
    .ic_stb, .ic_io, .ic_we, .ic_off, .ic_len, .ic_wdata, .ic_rdata);

  function automatic logic [7:0] init_byte(int unsigned k);
    return k[7:0] ^ k[15:8] ^ k[29:22] ^ 8'h3C;
  endfunction
  function logic [7:0] dget(int unsigned k);
    if (dev_mem.exists(k)) return dev_mem[k];
    return init_byte(k);
  endfunction
  function logic [7:0] rget(int unsigned k);
    if (ref_mem.exists(k)) return ref_mem[k];
    return init_byte(k);
  endfunction
  function automatic logic [31:0] ic_val(logic io, logic [11:0] off);
    return {4'hA, 7'h0, io, 8'h0, off};
  endfunction
  function automatic logic [31:0] am(logic [31:0] a, logic en);
    return en ? a : {a[31:21], 1'b0, a[19:0]};
  endfunction
  // 0 ram, 1 video, 2 shadow, 3 rom/drop, 4 unbacked, 5 reserved
  function int classify(logic [31:0] a, bit wr);
    logic [1:0] at;
    if (a >= 32'hA0000 && a < 32'hC0000) return 1;
    if (a >= 32'hC0000 && a < 32'h100000) begin
      at = wr ? wtbl[2*a[17:14] +: 2] : rtbl[2*a[17:14] +: 2];
      return (at == 2'd0) ? 3 : (at == 2'd1) ? 2 : 5;
    end
    if ({1'b0, a} < MEM) return 0;
    return 4;
  endfunction

  // target models
  always @(posedge clk) begin
    if (ram_stb && ram_we)
      for (int i = 0; i < 4; i++)
        if (ram_be[i]) dev_mem[K_RAM | ((ram_addr + i) & 32'h0FFF_FFFF)] = ram_wdata[8*i +: 8];
    if (vid_stb && vid_we) dev_mem[K_VID | vid_off] = vid_wdata;
    if (shd_stb && shd_we) dev_mem[K_SHD | shd_off] = shd_wdata;
    if ((ram_stb && ram_we) || (vid_stb && vid_we) || (shd_stb && shd_we)) wgen++;
    if (ram_stb || vid_stb || shd_stb || ic_stb) stb_cnt++;
    if (ic_stb) begin l_io = ic_io; l_we = ic_we; l_off = ic_off; l_len = ic_len; l_wd = ic_wdata; end
  end
  always @(ram_addr or vid_off or shd_off or wgen) begin
    for (int i = 0; i < 4; i++) ram_rdata[8*i +: 8] = dget(K_RAM | ((ram_addr + i) & 32'h0FFF_FFFF));
    vid_rdata = dget(K_VID | vid_off);
    shd_rdata = dget(K_SHD | shd_off);
  end
  assign ic_rdata = ic_val(ic_io, ic_off);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_op(string req, bit wr, logic [31:0] addr, logic [2:0] len,
                       logic [31:0] wd, int hold);
    bit err = 0, ic = 0, fast, icio = 0;
    int lat, exp_lat, s0;
    int cls [4];
    logic [31:0] bad [4];
    logic [31:0] er = '0, start, held;
    start = am(addr, a20_en);
    if (len == 0 || len > 4) err = 1;
    else if ((start & 32'hFFFF_F000) == 32'hFEE0_0000) ic = 1;
    else if ((start & 32'hFFFF_F000) == 32'hFEC0_0000) begin ic = 1; icio = 1; end
    else for (int i = 0; i < len; i++) begin
      bad[i] = am(addr + i, a20_en); cls[i] = classify(bad[i], wr);
      if (cls[i] == 5) err = 1;
    end
    fast = !err && !ic && (len == 1 || len == 2 || len == 4) &&
           ((start & 32'hFFF8_0000) != 32'h0008_0000) && ({1'b0, start} + len <= MEM);
    exp_lat = (err || ic || fast) ? 2 : 1 + len;
    if (fast) for (int i = 0; i < len; i++) begin bad[i] = start + i; cls[i] = 0; end
    if (!err && !ic) for (int i = 0; i < len; i++) begin
      logic [7:0] b; b = wd[8*i +: 8];
      case (cls[i])
        0: if (wr) ref_mem[K_RAM | bad[i]] = b; else er[8*i +: 8] = rget(K_RAM | bad[i]);
        1: if (wr) ref_mem[K_VID | bad[i][16:0]] = b; else er[8*i +: 8] = rget(K_VID | bad[i][16:0]);
        2: if (wr) ref_mem[K_SHD | bad[i][17:0]] = b; else er[8*i +: 8] = rget(K_SHD | bad[i][17:0]);
        3: if (!wr) er[8*i +: 8] = rget(K_RAM | bad[i]);
        default: if (!wr) er[8*i +: 8] = 8'hFF;
      endcase
    end
    if (ic && !wr) er = ic_val(icio, start[11:0]);
    if (wr) er = '0;

    while (!req_ready) @(negedge clk);
    s0 = stb_cnt;
    req_valid = 1; req_write = wr; req_addr = addr; req_len = len; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!rsp_valid && lat < 20) begin @(negedge clk); lat++; end
    chk(req, "latency", lat, exp_lat);
    chk(req, "err", {31'b0, rsp_err}, {31'b0, err});
    chk(req, "rdata", rsp_rdata, er);
    if (err) chk("R6", "strobes", stb_cnt - s0, 0);
    if (hold > 0) begin
      held = rsp_rdata;
      repeat (hold) @(negedge clk);
      chk("R11", "held valid", {31'b0, rsp_valid}, 32'd1);
      chk("R11", "held data", rsp_rdata, held);
    end
    if (ic) begin
      chk("R10", "ic target", {19'b0, l_io, l_we, l_len, l_off[7:0]},
          {19'b0, icio, wr, len, start[7:0]});
      if (wr) chk("R10", "ic wdata", l_wd, wd);
    end
    if (wr && !err && !ic) for (int i = 0; i < len; i++) begin
      chk(req, "ram byte", {24'b0, dget(K_RAM | bad[i])}, {24'b0, rget(K_RAM | bad[i])});
      chk(req, "vid byte", {24'b0, dget(K_VID | bad[i][16:0])}, {24'b0, rget(K_VID | bad[i][16:0])});
      chk(req, "shd byte", {24'b0, dget(K_SHD | bad[i][17:0])}, {24'b0, rget(K_SHD | bad[i][17:0])});
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  function automatic logic [31:0] pick_addr();
    case ($urandom % 8)
      0: return $urandom % 32'h80000;
      1: return 32'h80000 + $urandom % 32'h20000;
      2: return 32'hA0000 + $urandom % 32'h20000;
      3, 4: return 32'hC0000 + $urandom % 32'h40000;
      5: return 32'h100000 + $urandom % 32'h300000;
      6: return 32'h3FFFF8 + $urandom % 16;
      default: return 32'h7FFFC + $urandom % 8;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R11", "reset ready", {31'b0, req_ready}, 32'd1);
    chk("R11", "reset busy", {31'b0, busy}, 32'd0);
    chk("R11", "reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    do_op("R8", 0, 32'h1000, 3'd4, '0, 0);
    do_op("R8", 0, 32'h1000, 3'd3, '0, 0);
    do_op("R9", 1, 32'h2000, 3'd4, 32'h1122_3344, 0);
    do_op("R9", 0, 32'h2001, 3'd1, '0, 0);
    do_op("R9", 0, 32'h2002, 3'd2, '0, 0);
    do_op("R2", 1, 32'h90000, 3'd4, 32'hCAFE_F00D, 0);
    do_op("R2", 0, 32'h90000, 3'd4, '0, 0);
    do_op("R3", 1, 32'hA1230, 3'd2, 32'h0000_BEEF, 0);
    do_op("R3", 0, 32'hA1230, 3'd2, '0, 0);
    wtbl = 32'h0000_0004; rtbl = 32'h0000_0004;
    do_op("R4", 1, 32'hC4000, 3'd4, 32'hA5A5_5A5A, 0);
    do_op("R4", 1, 32'hC8000, 3'd2, 32'h0000_1234, 0);
    do_op("R5", 0, 32'hC4000, 3'd4, '0, 0);
    do_op("R5", 0, 32'hC8000, 3'd2, '0, 0);
    do_op("R4", 1, 32'hC7FFE, 3'd4, 32'h0102_0304, 0);
    wtbl = 32'h0000_00C4;
    do_op("R6", 1, 32'hCC000, 3'd1, 32'h77, 0);
    do_op("R6", 1, 32'hCBFFE, 3'd4, 32'h8888_8888, 0);
    do_op("R6", 0, 32'h3000, 3'd0, '0, 0);
    do_op("R6", 1, 32'h3000, 3'd5, 32'h1, 0);
    do_op("R7", 1, 32'h3FFFFE, 3'd4, 32'hDEAD_BEEF, 0);
    do_op("R7", 0, 32'h3FFFFE, 3'd4, '0, 0);
    do_op("R7", 0, 32'h500000, 3'd2, '0, 0);
    a20_en = 0;
    do_op("R1", 1, 32'h112340, 3'd4, 32'h5566_7788, 0);
    a20_en = 1;
    do_op("R1", 0, 32'h012340, 3'd4, '0, 0);
    do_op("R10", 0, 32'hFEE00020, 3'd4, '0, 0);
    do_op("R10", 1, 32'hFEC00010, 3'd4, 32'h0BAD_CAFE, 0);
    do_op("R11", 0, 32'h2000, 3'd4, '0, 3);

    wtbl = '0; rtbl = '0; last_a = 32'h1000;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a; logic [2:0] l; bit w;
      if (n % 20 == 0) begin
        for (int s = 0; s < 16; s++) begin
          wtbl[2*s +: 2] = {1'b0, 1'($urandom)};
          rtbl[2*s +: 2] = {1'b0, 1'($urandom)};
        end
      end
      a = ($urandom % 2) ? last_a : pick_addr();
      l = 3'(1 + $urandom % 4);
      w = 1'($urandom);
      if (w) last_a = a;
      do_op(w ? "R2/R9 random write" : "R5/R9 random read", w, a, l, $urandom, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule